// File: doc/BRIEF.md
# Clock Fan-Out Divider Network

This block is the digital output stage of a phase-locked clock fan-out buffer. It chooses one of two reference clocks and then chooses the clock that drives the output registers. In normal operation that clock is the fast loop oscillator. In test-bypass mode it is the chosen reference, inverted. An optional divide-by-two stage can follow. A small register chain then produces a double-rate clock, a group of in-phase mid-rate clocks with one inverted copy, and a half-rate clock. A single active-low control both clears the divider registers and turns every output off. The turned-off state is reported as a per-output enable flag, which stands in for a real tri-state pad.

All clocks are modelled as sampled levels on a fast system clock `clk`. Each output register reacts to a rising edge of its source, as seen in the samples, and changes at the first `clk` edge where that edge is visible. This makes one `clk` cycle of latency from a source change to the outputs. The analog loop (phase detector, charge pump, oscillator and lock indication) lies outside the block, and the oscillator arrives as a plain input.

Top module: `clkfan_divider`

## Requirements
- R1: `ref_pick` low selects `ref_clk0` and high selects `ref_clk1`. The reference that is not selected has no effect on any output.
- R2: With `pll_on` high, the source is `osc_clk` in its own polarity and the references are ignored. With `fsel` high, `x2_clk` equals the `osc_clk` value from one `clk` cycle earlier.
- R3: With `pll_on` low, the source is the inverse of the selected reference and `osc_clk` is ignored. With `fsel` high, `x2_clk` equals the inverted reference value from one `clk` cycle earlier. The mid-rate and half-rate clocks therefore advance on falling reference edges.
- R4: With `fsel` low, a divide-by-two stage sits between the source and `x2_clk`, so `x2_clk` rises once for every two source rising edges. This holds in both normal and bypass modes.
- R5: The mid-rate clocks toggle at each rising edge of `x2_clk` and hold otherwise. `half_clk` toggles at each rising edge of the mid-rate clocks and holds otherwise. Over N source rising edges with `fsel` high, the rising-edge counts are N, N/2 and N/4.
- R6: All `NUM_Q` bits of `q_clk` are equal at every sample, and `qb_clk` is always their complement.
- R7: While `oe_rst_n` is low, every enable flag is 0. Also, without waiting for a `clk` edge, `q_clk` is all zeros, `qb_clk` is 1 and `half_clk` is 0.
- R8: While `oe_rst_n` is high, every enable flag is 1.
- R9: After `oe_rst_n` rises, a source that is already high is not counted as an edge. The first true source rising edge takes `q_clk` and `half_clk` high, and in divide-by-two mode it also takes `x2_clk` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all registers |
| oe_rst_n | input | 1 | Active low: async clear of the dividers and all outputs disabled |
| ref_clk0 | input | 1 | Reference clock 0 |
| ref_clk1 | input | 1 | Reference clock 1 |
| ref_pick | input | 1 | Reference select (0: ref_clk0, 1: ref_clk1) |
| osc_clk | input | 1 | Loop oscillator clock |
| pll_on | input | 1 | 1: oscillator source; 0: bypass with the inverted reference |
| fsel | input | 1 | 1: no prescale; 0: extra divide-by-two |
| x2_clk | output | 1 | Double-rate clock |
| x2_en | output | 1 | Enable flag of x2_clk |
| q_clk | output | NUM_Q | In-phase mid-rate clocks |
| q_en | output | NUM_Q | Enable flags of q_clk |
| qb_clk | output | 1 | Inverted mid-rate clock |
| qb_en | output | 1 | Enable flag of qb_clk |
| half_clk | output | 1 | Half-rate clock |
| half_en | output | 1 | Enable flag of half_clk |

## Verification
Every combination of `pll_on` and `fsel` is run for sixteen source periods while the rising edges of the three output rates are counted. A count of 16/8/4 against 8/4/2 tells whether the prescaler is present. The bypass runs are repeated with each value of `ref_pick` while the other reference and the oscillator toggle every cycle, so a wrong source choice shows up as a doubled count. Directed patterns hold the source high across reset release to separate a level from an edge, and they pulse a single reference low to expose the inverted polarity. Reset is also asserted while the mid-rate clock is high, and the outputs are checked before the next `clk` edge to prove that the clear is asynchronous.

// File: rtl/clkfan_pkg.sv
// Shared definitions for the clock fan-out divider network.
// Assumes: nothing beyond IEEE 1800-2017.
package clkfan_pkg;

    // Number of toggle stages after the double-rate clock (mid-rate, half-rate).
    localparam int unsigned DIV_STAGES = 2;

    // Stage indices inside the divider chain.
    localparam int unsigned STG_Q    = 0;
    localparam int unsigned STG_HALF = 1;

    // Register values loaded while the control input is low.
    localparam logic SRC_PREV_INIT = 1'b1;  // a source high at release is not an edge
    localparam logic X2_INIT       = 1'b1;  // double-rate register parked high
    localparam logic DIV_INIT      = 1'b0;  // divider stages start low

    // Source choice of the bypass multiplexer.
    typedef enum logic {
        SRC_BYPASS = 1'b0,
        SRC_LOOP   = 1'b1
    } src_mode_e;

endpackage

// File: rtl/clkfan_src_mux.sv
// Source selection for the divider network.
// Picks one of two references, then chooses between the loop oscillator and
// the inverted chosen reference. The inversion gives the bypass path the
// opposite output polarity. Purely combinational; inputs are sampled levels.
module clkfan_src_mux
    import clkfan_pkg::*;
(
    input  logic ref_clk0,
    input  logic ref_clk1,
    input  logic ref_pick,
    input  logic osc_clk,
    input  logic pll_on,
    output logic src_lvl
);

    logic      ref_lvl;
    src_mode_e mode;

    // Reference choice and bypass choice.
    always_comb begin
        ref_lvl = ref_pick ? ref_clk1 : ref_clk0;
        mode    = pll_on ? SRC_LOOP : SRC_BYPASS;
        src_lvl = (mode == SRC_LOOP) ? osc_clk : ~ref_lvl;
    end

endmodule

// File: rtl/clkfan_prescale.sv
// Optional divide-by-two between the source and the double-rate clock.
// Rising edges of the source are found by comparison with the previous
// sample. The prescaler toggles on each edge; fsel high bypasses it. Also
// reports the cycle in which the double-rate register rises.
// Assumes: src_lvl is synchronous to clk; rst_n is an asynchronous clear.
module clkfan_prescale
    import clkfan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_lvl,
    input  logic fsel,
    output logic x2_q,
    output logic x2_rise
);

    logic src_prev;
    logic div2_q;
    logic div2_next;
    logic x2_next;
    logic src_rise;

    // Next-state logic for the prescaler and the double-rate register.
    always_comb begin
        src_rise  = src_lvl & ~src_prev;
        div2_next = div2_q ^ src_rise;
        x2_next   = fsel ? src_lvl : div2_next;
        x2_rise   = x2_next & ~x2_q;
    end

    // Edge history, prescaler and double-rate registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_prev <= SRC_PREV_INIT;
            div2_q   <= DIV_INIT;
            x2_q     <= X2_INIT;
        end else begin
            src_prev <= src_lvl;
            div2_q   <= div2_next;
            x2_q     <= x2_next;
        end
    end

endmodule

// File: rtl/clkfan_div_chain.sv
// Chain of toggle stages driven by rising edges of the double-rate clock.
// Stage k toggles when stage k-1 is about to rise, which is when all lower
// stages are low and the chain is stepped. The whole chain updates in the
// same cycle as the double-rate register.
// Assumes: rst_n is an asynchronous clear; STAGES >= 1.
module clkfan_div_chain
    import clkfan_pkg::*;
#(
    parameter int unsigned STAGES = DIV_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [STAGES-1:0] stage_q
);

    logic [STAGES-1:0] stage_next;

    // Ripple the toggle condition from stage to stage.
    always_comb begin
        logic carry;
        carry = step;
        for (int k = 0; k < STAGES; k++) begin
            stage_next[k] = stage_q[k] ^ carry;
            carry         = carry & ~stage_q[k];
        end
    end

    // Stage registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{DIV_INIT}};
        end else begin
            stage_q <= stage_next;
        end
    end

endmodule

// File: rtl/clkfan_fanout.sv
// Output fan-out: copies the mid-rate clock NUM_Q times, adds its inverted
// copy and gives every output an enable flag that follows the control input.
// Assumes: the flags stand in for tri-state pad controls.
module clkfan_fanout #(
    parameter int unsigned NUM_Q = 5
) (
    input  logic             oe_n_ctl,
    input  logic             x2_lvl,
    input  logic             q_lvl,
    input  logic             half_lvl,
    output logic             x2_clk,
    output logic             x2_en,
    output logic [NUM_Q-1:0] q_clk,
    output logic [NUM_Q-1:0] q_en,
    output logic             qb_clk,
    output logic             qb_en,
    output logic             half_clk,
    output logic             half_en
);

    // One copy and one enable flag per in-phase output.
    for (genvar i = 0; i < NUM_Q; i++) begin : g_qcopy
        assign q_clk[i] = q_lvl;
        assign q_en[i]  = oe_n_ctl;
    end

    // Single outputs and their enable flags.
    always_comb begin
        x2_clk   = x2_lvl;
        qb_clk   = ~q_lvl;
        half_clk = half_lvl;
        x2_en    = oe_n_ctl;
        qb_en    = oe_n_ctl;
        half_en  = oe_n_ctl;
    end

endmodule

// File: rtl/clkfan_divider.sv
// Clock fan-out divider network, top level.
// Chooses the source (oscillator or inverted reference) and applies the
// optional prescale. Derives double-rate, mid-rate and half-rate clocks and
// fans them out with enable flags. oe_rst_n low clears the dividers
// asynchronously and disables every output.
// Assumes: all clock inputs are levels synchronous to clk.
module clkfan_divider
    import clkfan_pkg::*;
#(
    parameter int unsigned NUM_Q = 5
) (
    input  logic             clk,
    input  logic             oe_rst_n,
    input  logic             ref_clk0,
    input  logic             ref_clk1,
    input  logic             ref_pick,
    input  logic             osc_clk,
    input  logic             pll_on,
    input  logic             fsel,
    output logic             x2_clk,
    output logic             x2_en,
    output logic [NUM_Q-1:0] q_clk,
    output logic [NUM_Q-1:0] q_en,
    output logic             qb_clk,
    output logic             qb_en,
    output logic             half_clk,
    output logic             half_en
);

    logic                  src_lvl;
    logic                  x2_q;
    logic                  x2_rise;
    logic [DIV_STAGES-1:0] div_q;

    clkfan_src_mux u_src (
        .ref_clk0 (ref_clk0),
        .ref_clk1 (ref_clk1),
        .ref_pick (ref_pick),
        .osc_clk  (osc_clk),
        .pll_on   (pll_on),
        .src_lvl  (src_lvl)
    );

    clkfan_prescale u_pre (
        .clk     (clk),
        .rst_n   (oe_rst_n),
        .src_lvl (src_lvl),
        .fsel    (fsel),
        .x2_q    (x2_q),
        .x2_rise (x2_rise)
    );

    clkfan_div_chain #(.STAGES(DIV_STAGES)) u_chain (
        .clk     (clk),
        .rst_n   (oe_rst_n),
        .step    (x2_rise),
        .stage_q (div_q)
    );

    clkfan_fanout #(.NUM_Q(NUM_Q)) u_out (
        .oe_n_ctl (oe_rst_n),
        .x2_lvl   (x2_q),
        .q_lvl    (div_q[STG_Q]),
        .half_lvl (div_q[STG_HALF]),
        .x2_clk   (x2_clk),
        .x2_en    (x2_en),
        .q_clk    (q_clk),
        .q_en     (q_en),
        .qb_clk   (qb_clk),
        .qb_en    (qb_en),
        .half_clk (half_clk),
        .half_en  (half_en)
    );

endmodule

// File: rtl/clkfan_divider_checker.sv
// Property checker for the clock fan-out divider network; bound to the top.
// Assumes: the same clk and oe_rst_n as the design.
module clkfan_divider_checker #(
    parameter int unsigned NUM_Q = 5
) (
    input logic             clk,
    input logic             oe_rst_n,
    input logic             ref_clk0,
    input logic             ref_clk1,
    input logic             ref_pick,
    input logic             osc_clk,
    input logic             pll_on,
    input logic             fsel,
    input logic             x2_clk,
    input logic [NUM_Q-1:0] q_clk,
    input logic             qb_clk,
    input logic             half_clk
);

    AST_OSC_TO_X2: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (pll_on && fsel) |=> (x2_clk == $past(osc_clk))); // R2

    AST_REF0_INVERTED: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (!pll_on && fsel && !ref_pick) |=> (x2_clk == !$past(ref_clk0))); // R3

    AST_REF1_INVERTED: assert property (@(posedge clk) disable iff (!oe_rst_n)
        (!pll_on && fsel && ref_pick) |=> (x2_clk == !$past(ref_clk1))); // R1

    AST_Q_STEPS_ON_X2: assert property (@(posedge clk) disable iff (!oe_rst_n)
        $rose(x2_clk) |-> (q_clk == ~$past(q_clk)) && (qb_clk == !$past(qb_clk))); // R5

    AST_Q_HOLDS: assert property (@(posedge clk) disable iff (!oe_rst_n)
        !$rose(x2_clk) |-> $stable(q_clk) && $stable(qb_clk)); // R5

    AST_HALF_STEPS_ON_Q: assert property (@(posedge clk) disable iff (!oe_rst_n)
        $rose(q_clk[0]) |-> (half_clk != $past(half_clk))); // R5

    AST_HALF_HOLDS: assert property (@(posedge clk) disable iff (!oe_rst_n)
        !$rose(q_clk[0]) |-> $stable(half_clk)); // R5

    AST_CLEAR_AT_RELEASE: assert property (@(posedge clk) disable iff (!oe_rst_n)
        $rose(oe_rst_n) |-> (q_clk == '0) && qb_clk && !half_clk); // R9

endmodule

bind clkfan_divider clkfan_divider_checker #(.NUM_Q(NUM_Q)) u_chk (
    .clk      (clk),
    .oe_rst_n (oe_rst_n),
    .ref_clk0 (ref_clk0),
    .ref_clk1 (ref_clk1),
    .ref_pick (ref_pick),
    .osc_clk  (osc_clk),
    .pll_on   (pll_on),
    .fsel     (fsel),
    .x2_clk   (x2_clk),
    .q_clk    (q_clk),
    .qb_clk   (qb_clk),
    .half_clk (half_clk)
);

// File: tb/clkfan_divider_test.sv
`timescale 1ns/1ps
// Self-checking bench for the clock fan-out divider network.
module clkfan_divider_test;

    localparam int NUM_Q = 5;

    logic clk = 1'b0;
    logic oe_rst_n = 1'b0;
    logic ref_clk0 = 1'b1;
    logic ref_clk1 = 1'b1;
    logic ref_pick = 1'b0;
    logic osc_clk = 1'b0;
    logic pll_on = 1'b1;
    logic fsel = 1'b1;
    logic x2_clk, x2_en, qb_clk, qb_en, half_clk, half_en;
    logic [NUM_Q-1:0] q_clk, q_en;

    clkfan_divider #(.NUM_Q(NUM_Q)) uut (
        .clk(clk), .oe_rst_n(oe_rst_n), .ref_clk0(ref_clk0), .ref_clk1(ref_clk1),
        .ref_pick(ref_pick), .osc_clk(osc_clk), .pll_on(pll_on), .fsel(fsel),
        .x2_clk(x2_clk), .x2_en(x2_en), .q_clk(q_clk), .q_en(q_en),
        .qb_clk(qb_clk), .qb_en(qb_en), .half_clk(half_clk), .half_en(half_en)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Edge counters and complement-mismatch counter, updated by cyc().
    int cnt_x2, cnt_q, cnt_half, cnt_mis;
    logic p_x2, p_q, p_half;

    typedef struct packed {
        logic       pll;
        logic       fs;
        logic       pick;
        logic [4:0] e_x2;
        logic [3:0] e_q;
        logic [2:0] e_half;
    } vec_t;

    // pll_on, fsel, ref_pick, expected rises of x2 / q / half over 16 periods
    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 1'b0, 5'd16, 4'd8, 3'd4},
        '{1'b1, 1'b0, 1'b1, 5'd8,  4'd4, 3'd2},
        '{1'b0, 1'b1, 1'b0, 5'd16, 4'd8, 3'd4},
        '{1'b0, 1'b1, 1'b1, 5'd16, 4'd8, 3'd4},
        '{1'b0, 1'b0, 1'b0, 5'd8,  4'd4, 3'd2},
        '{1'b0, 1'b0, 1'b1, 5'd8,  4'd4, 3'd2}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clk cycle: wait for the edge, sample 2 ns later, update counters.
    task automatic cyc();
        @(posedge clk);
        #2;
        if (x2_clk && !p_x2) cnt_x2++;
        if (q_clk[0] && !p_q) cnt_q++;
        if (half_clk && !p_half) cnt_half++;
        if (q_clk !== {NUM_Q{q_clk[0]}} || qb_clk !== ~q_clk[0]) cnt_mis++;
        p_x2 = x2_clk; p_q = q_clk[0]; p_half = half_clk;
    endtask

    task automatic clear_counts();
        cnt_x2 = 0; cnt_q = 0; cnt_half = 0; cnt_mis = 0;
        p_x2 = x2_clk; p_q = q_clk[0]; p_half = half_clk;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        oe_rst_n = 1'b0;
        pll_on = v.pll; fsel = v.fs; ref_pick = v.pick;
        osc_clk = 1'b0; ref_clk0 = 1'b1; ref_clk1 = 1'b1;
        cyc(); cyc();
        oe_rst_n = 1'b1;
        cyc(); cyc();
        clear_counts();
        for (int p = 0; p < 16; p++) begin
            for (int h = 0; h < 4; h++) begin
                logic act;
                act = (h < 2);
                if (v.pll) begin
                    osc_clk  = act;
                    ref_clk0 = ~ref_clk0;      // noise, must be ignored (R2)
                    ref_clk1 = ~ref_clk1;
                end else begin
                    osc_clk = ~osc_clk;        // noise, must be ignored (R3)
                    if (v.pick) begin
                        ref_clk1 = ~act;
                        ref_clk0 = ~ref_clk0;  // unselected reference (R1)
                    end else begin
                        ref_clk0 = ~act;
                        ref_clk1 = ~ref_clk1;
                    end
                end
                cyc();
            end
        end
        cyc(); cyc();
        chk($sformatf("R1/R2/R3/R4 vec%0d x2 rises", idx), cnt_x2, int'(v.e_x2));
        chk($sformatf("R4/R5 vec%0d q rises", idx), cnt_q, int'(v.e_q));
        chk($sformatf("R5 vec%0d half rises", idx), cnt_half, int'(v.e_half));
        chk($sformatf("R6 vec%0d complement mismatches", idx), cnt_mis, 0);
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        clear_counts();
        // Reset state (R7) with outputs disabled.
        cyc(); cyc();
        chk("R7 enables off in reset", {x2_en, q_en, qb_en, half_en}, 0);
        chk("R7 q low in reset", q_clk, 0);
        chk("R7 qb high in reset", qb_clk, 1);
        chk("R7 half low in reset", half_clk, 0);
        oe_rst_n = 1'b1;
        #1;
        chk("R8 enables on after release", {x2_en, q_en, qb_en, half_en}, {(NUM_Q+3){1'b1}});

        // Normal polarity (R2): x2 follows osc one cycle later.
        cyc(); cyc();
        osc_clk = 1'b1; cyc();
        chk("R2 x2 high after osc high", x2_clk, 1);
        osc_clk = 1'b0; cyc();
        chk("R2 x2 low after osc low", x2_clk, 0);

        // Table-driven edge counts.
        for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

        // Level at release is no edge; first true edge raises all (R9, R3).
        oe_rst_n = 1'b0;
        pll_on = 1'b0; fsel = 1'b1; ref_pick = 1'b0;
        ref_clk0 = 1'b0; ref_clk1 = 1'b1; osc_clk = 1'b0;
        cyc(); cyc();
        oe_rst_n = 1'b1;
        cyc(); cyc(); cyc();
        chk("R3 x2 is inverted reference", x2_clk, 1);
        chk("R9 held level not an edge", q_clk[0], 0);
        ref_clk0 = 1'b1; cyc();
        chk("R3 x2 low after reference high", x2_clk, 0);
        ref_clk0 = 1'b0; cyc();
        chk("R9 q high on first edge", q_clk, {NUM_Q{1'b1}});
        chk("R9 half high on first edge", half_clk, 1);

        // Asynchronous clear while q is high (R7).
        oe_rst_n = 1'b0;
        #3;
        chk("R7 async q clear", q_clk, 0);
        chk("R7 async qb set", qb_clk, 1);
        chk("R7 async half clear", half_clk, 0);
        chk("R7 async enables off", {x2_en, q_en, qb_en, half_en}, 0);

        // Prescale first edge in divide-by-two mode (R9, R4).
        fsel = 1'b0; pll_on = 1'b1; osc_clk = 1'b1;
        cyc();
        oe_rst_n = 1'b1;
        cyc(); cyc();
        chk("R9 x2 not raised by held osc", x2_clk, 0);
        osc_clk = 1'b0; cyc();
        osc_clk = 1'b1; cyc();
        chk("R4 x2 high on first osc edge", x2_clk, 1);
        chk("R9 q high on first osc edge", q_clk[0], 1);
        osc_clk = 1'b0; cyc();
        osc_clk = 1'b1; cyc();
        chk("R4 x2 low on second osc edge", x2_clk, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule